// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block carries out in-band software flow control for a UART in both directions. On the receive path it compares every received character with four programmable codes, two resume codes (set A and set B) and two pause codes (set A and set B). A recognised flow character is taken out of the receive stream. It records a sticky status bit, and it pauses or resumes the local transmitter. The pause never cuts a character that is already on the line: it takes effect only once the transmitter reports that it is idle.

On the transmit path the block watches the fill level of the receive FIFO. It compares that level with a halt threshold and a resume threshold. Both thresholds are programmed in steps of eight words. When the level reaches the halt threshold the block requests that a pause code be inserted into the transmit stream. When the level drains to the resume threshold it requests a resume code. An insertion request takes precedence over ordinary queued data. Two independent 2-bit mode fields select which code set is recognised and which code set is generated. In the mode that uses both sets, the two codes are treated as an ordered two-character sequence.

Top module: `swflow_ctrl`

## Requirements
- R1: The reset state is `tx_pause`=0, `inj_req`=0, `stat`=0, `rx_fwd_valid`=0 and `data_grant`=1.
- R2: With `cmp_mode`=00, every received character appears on `rx_fwd_valid`/`rx_fwd_char` one cycle after its strobe. No character changes `tx_pause` or `stat`.
- R3: With `cmp_mode`=01, only the set-B codes are recognised. `xoff_b_code` requests a pause and `xon_b_code` resumes. The set-A codes pass through as data.
- R4: With `cmp_mode`=10, only the set-A codes are recognised. `xoff_a_code` requests a pause and `xon_a_code` resumes. The set-B codes pass through as data.
- R5: With `cmp_mode`=11, any of the four codes is consumed and records its status bit. A pause happens only when `xoff_a_code` is directly followed, as the next received character, by `xoff_b_code`. A resume happens only when `xon_a_code` is directly followed by `xon_b_code`. Any other character in between breaks the pair.
- R6: A recognised pause takes effect on `tx_pause` one cycle after the strobe if `tx_busy` is low. Otherwise it is held pending and sets `tx_pause` one cycle after `tx_busy` goes low. A recognised resume clears `tx_pause` and any pending pause one cycle after its strobe.
- R7: A recognised flow character is never forwarded, so `rx_fwd_valid` stays low in the cycle after its strobe.
- R8: The `stat` bits are bit0 = set-A resume code, bit1 = set-B resume code, bit2 = set-A pause code and bit3 = set-B pause code. Each bit is sticky. `stat_clr` clears the register, except that a match in the same cycle as `stat_clr` is kept.
- R9: `thresh_cfg[3:0]` times 8 is the halt level and `thresh_cfg[7:4]` times 8 is the resume level.
- R10: A pause code is requested once, when `fifo_level` is at or above the halt level. A resume code is requested once, after that, when `fifo_level` is at or below the resume level. A level that stays put causes no repeat.
- R11: `gen_mode` 01 sends the set-B code and 10 sends the set-A code. 11 sends the set-A code followed by the set-B code as two requests. 00 sends nothing.
- R12: `inj_req` and `inj_char` hold until a cycle with `inj_ack` high. `data_grant` is low whenever `inj_req` or `tx_pause` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | CHAR_W | Received character |
| cmp_mode | input | 2 | Receive recognition mode |
| gen_mode | input | 2 | Transmit generation mode |
| xon_a_code | input | CHAR_W | Set-A resume code |
| xon_b_code | input | CHAR_W | Set-B resume code |
| xoff_a_code | input | CHAR_W | Set-A pause code |
| xoff_b_code | input | CHAR_W | Set-B pause code |
| fifo_level | input | clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| thresh_cfg | input | 2*THR_W | Halt level in the low nibble, resume level in the high nibble, each in steps of STEP words |
| tx_busy | input | 1 | Transmitter is shifting a character |
| inj_ack | input | 1 | Transmitter accepts the requested flow character |
| stat_clr | input | 1 | Clear the sticky status bits |
| rx_fwd_valid | output | 1 | Forwarded data character is valid |
| rx_fwd_char | output | CHAR_W | Forwarded data character |
| tx_pause | output | 1 | Local transmitter is paused |
| data_grant | output | 1 | Queued data may be sent |
| inj_req | output | 1 | Request to insert a flow character |
| inj_char | output | CHAR_W | Flow character to insert |
| stat | output | 4 | Sticky match status bits |

## Verification
The assertions assume that the four codes are distinct and stay constant while characters arrive. They also assume that `inj_ack` is raised only while `inj_req` is high, and that `fifo_level` never exceeds the FIFO depth. The stimulus programs four distinct codes once, before any traffic. It raises `inj_ack` only for one cycle after it has seen a pending request, and it moves `fifo_level` only between 0 and 60. The sequence-mode checks depend on characters being strobed back to back, so the bench drives each character for exactly one cycle and changes modes only while the receive line is idle.

// File: rtl/swflow_pkg.sv
`timescale 1ns/1ps
package swflow_pkg;
  localparam int N_LANES = 4;
  // lane order is also the status bit order
  localparam int LANE_ON_A  = 0;
  localparam int LANE_ON_B  = 1;
  localparam int LANE_OFF_A = 2;
  localparam int LANE_OFF_B = 3;

  localparam logic [1:0] MODE_NONE = 2'b00;
  localparam logic [1:0] MODE_B    = 2'b01;
  localparam logic [1:0] MODE_A    = 2'b10;
  localparam logic [1:0] MODE_BOTH = 2'b11;

  function automatic logic [N_LANES-1:0] lane_enable(input logic [1:0] mode);
    case (mode)
      MODE_B:    lane_enable = 4'b1010;
      MODE_A:    lane_enable = 4'b0101;
      MODE_BOTH: lane_enable = 4'b1111;
      default:   lane_enable = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/swflow_rx_match.sv
`timescale 1ns/1ps
module swflow_rx_match
  import swflow_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rx_valid,
  input  logic [CHAR_W-1:0]               rx_char,
  input  logic [N_LANES-1:0][CHAR_W-1:0]  codes,
  input  logic [1:0]                      cmp_mode,
  output logic [N_LANES-1:0]              hit,
  output logic                            req_off,
  output logic                            req_on,
  output logic                            fwd_valid,
  output logic [CHAR_W-1:0]               fwd_char
);
  logic [N_LANES-1:0] eq;
  logic               armed_off, armed_on;
  logic               pair_mode;

  for (genvar i = 0; i < N_LANES; i++) begin : g_cmp
    assign eq[i] = (rx_char == codes[i]);
  end

  assign hit       = eq & lane_enable(cmp_mode) & {N_LANES{rx_valid}};
  assign pair_mode = (cmp_mode == MODE_BOTH);

  always_comb begin
    if (pair_mode) begin
      req_off = hit[LANE_OFF_B] & armed_off;
      req_on  = hit[LANE_ON_B] & armed_on;
    end else begin
      req_off = hit[LANE_OFF_A] | hit[LANE_OFF_B];
      req_on  = (hit[LANE_ON_A] | hit[LANE_ON_B]) & ~req_off;
    end
  end

  // first half of a pair is remembered only until the next character
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_off <= 1'b0;
      armed_on  <= 1'b0;
    end else if (rx_valid) begin
      armed_off <= hit[LANE_OFF_A];
      armed_on  <= hit[LANE_ON_A];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_char  <= '0;
    end else begin
      fwd_valid <= rx_valid & ~(|hit);
      if (rx_valid) fwd_char <= rx_char;
    end
  end

  // R7: flow characters are swallowed
  p_consume_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (|hit)) |=> !fwd_valid);

  // R2: with recognition off every character passes
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cmp_mode == MODE_NONE) |=> (fwd_valid && fwd_char == $past(rx_char)));
endmodule

// File: rtl/swflow_pause_status.sv
`timescale 1ns/1ps
module swflow_pause_status
  import swflow_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LANES-1:0] hit,
  input  logic               req_off,
  input  logic               req_on,
  input  logic               tx_busy,
  input  logic               stat_clr,
  output logic               tx_pause,
  output logic [N_LANES-1:0] stat
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pause <= 1'b0;
      pend     <= 1'b0;
    end else if (req_on) begin
      tx_pause <= 1'b0;
      pend     <= 1'b0;
    end else if (req_off) begin
      if (tx_busy) begin
        pend <= 1'b1;
      end else begin
        tx_pause <= 1'b1;
        pend     <= 1'b0;
      end
    end else if (pend && !tx_busy) begin
      tx_pause <= 1'b1;
      pend     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           stat <= '0;
    else if (stat_clr) stat <= hit;
    else               stat <= stat | hit;
  end

  // R6: the pause never starts while a character is on the line
  p_char_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_pause) |-> !$past(tx_busy));

  // R6: a resume always wins
  p_resume_r6: assert property (@(posedge clk) disable iff (rst)
    req_on |=> !tx_pause);

  // R8: without a clear no status bit is lost
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !stat_clr |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/swflow_level_mon.sv
`timescale 1ns/1ps
module swflow_level_mon
  import swflow_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int STEP       = 8,
  parameter int THR_W      = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
  input  logic [2*THR_W-1:0]                thresh_cfg,
  input  logic [1:0]                        gen_mode,
  input  logic                              busy,
  output logic                              start_off,
  output logic                              start_on
);
  localparam int LVL_W   = $clog2(FIFO_DEPTH+1);
  localparam int STEP_SH = $clog2(STEP);
  localparam int CMP_W   = LVL_W + THR_W + STEP_SH;

  logic [CMP_W-1:0] halt_lvl, res_lvl, lvl;
  logic             halted, en;

  assign halt_lvl = CMP_W'(thresh_cfg[THR_W-1:0]) << STEP_SH;
  assign res_lvl  = CMP_W'(thresh_cfg[2*THR_W-1:THR_W]) << STEP_SH;
  assign lvl      = CMP_W'(fifo_level);
  assign en       = (gen_mode != MODE_NONE);

  assign start_off = en & ~busy & ~halted & (lvl >= halt_lvl);
  assign start_on  = en & ~busy & halted & (lvl <= res_lvl);

  always_ff @(posedge clk) begin
    if (rst || !en)     halted <= 1'b0;
    else if (start_off) halted <= 1'b1;
    else if (start_on)  halted <= 1'b0;
  end

  // R10: each crossing is announced a single time
  p_once_r10: assert property (@(posedge clk) disable iff (rst)
    start_off |=> !start_off);
endmodule

// File: rtl/swflow_inj_seq.sv
`timescale 1ns/1ps
module swflow_inj_seq
  import swflow_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start_off,
  input  logic                            start_on,
  input  logic [1:0]                      gen_mode,
  input  logic [N_LANES-1:0][CHAR_W-1:0]  codes,
  input  logic                            inj_ack,
  output logic                            inj_req,
  output logic [CHAR_W-1:0]               inj_char
);
  logic              second_pend;
  logic [CHAR_W-1:0] second_char;
  logic [CHAR_W-1:0] code_a, code_b;

  assign code_a = start_off ? codes[LANE_OFF_A] : codes[LANE_ON_A];
  assign code_b = start_off ? codes[LANE_OFF_B] : codes[LANE_ON_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_req     <= 1'b0;
      inj_char    <= '0;
      second_pend <= 1'b0;
      second_char <= '0;
    end else if (inj_req) begin
      if (inj_ack) begin
        if (second_pend) begin
          inj_char    <= second_char;
          second_pend <= 1'b0;
        end else begin
          inj_req <= 1'b0;
        end
      end
    end else if (start_off || start_on) begin
      inj_req <= 1'b1;
      case (gen_mode)
        MODE_A:    inj_char <= code_a;
        MODE_BOTH: begin
          inj_char    <= code_a;
          second_char <= code_b;
          second_pend <= 1'b1;
        end
        default:   inj_char <= code_b;
      endcase
    end
  end

  // R12: request and character wait for the acknowledge
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (inj_req && !inj_ack) |=> (inj_req && $stable(inj_char)));

  // R11: generation off means no request ever starts
  p_gen_off_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(inj_req) |-> ($past(gen_mode) != MODE_NONE));
endmodule

// File: rtl/swflow_ctrl.sv
`timescale 1ns/1ps
module swflow_ctrl
  import swflow_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 128,
  parameter int STEP       = 8,
  parameter int THR_W      = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rx_valid,
  input  logic [CHAR_W-1:0]               rx_char,
  input  logic [1:0]                      cmp_mode,
  input  logic [1:0]                      gen_mode,
  input  logic [CHAR_W-1:0]               xon_a_code,
  input  logic [CHAR_W-1:0]               xon_b_code,
  input  logic [CHAR_W-1:0]               xoff_a_code,
  input  logic [CHAR_W-1:0]               xoff_b_code,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input  logic [2*THR_W-1:0]              thresh_cfg,
  input  logic                            tx_busy,
  input  logic                            inj_ack,
  input  logic                            stat_clr,
  output logic                            rx_fwd_valid,
  output logic [CHAR_W-1:0]               rx_fwd_char,
  output logic                            tx_pause,
  output logic                            data_grant,
  output logic                            inj_req,
  output logic [CHAR_W-1:0]               inj_char,
  output logic [N_LANES-1:0]              stat
);
  logic [N_LANES-1:0][CHAR_W-1:0] codes;
  logic [N_LANES-1:0]             hit;
  logic                           req_off, req_on;
  logic                           start_off, start_on;

  always_comb begin
    codes[LANE_ON_A]  = xon_a_code;
    codes[LANE_ON_B]  = xon_b_code;
    codes[LANE_OFF_A] = xoff_a_code;
    codes[LANE_OFF_B] = xoff_b_code;
  end

  swflow_rx_match #(.CHAR_W(CHAR_W)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .codes(codes), .cmp_mode(cmp_mode), .hit(hit),
    .req_off(req_off), .req_on(req_on),
    .fwd_valid(rx_fwd_valid), .fwd_char(rx_fwd_char)
  );

  swflow_pause_status u_pause (
    .clk(clk), .rst(rst), .hit(hit), .req_off(req_off), .req_on(req_on),
    .tx_busy(tx_busy), .stat_clr(stat_clr), .tx_pause(tx_pause), .stat(stat)
  );

  swflow_level_mon #(.FIFO_DEPTH(FIFO_DEPTH), .STEP(STEP), .THR_W(THR_W)) u_level (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .thresh_cfg(thresh_cfg),
    .gen_mode(gen_mode), .busy(inj_req),
    .start_off(start_off), .start_on(start_on)
  );

  swflow_inj_seq #(.CHAR_W(CHAR_W)) u_inj (
    .clk(clk), .rst(rst), .start_off(start_off), .start_on(start_on),
    .gen_mode(gen_mode), .codes(codes), .inj_ack(inj_ack),
    .inj_req(inj_req), .inj_char(inj_char)
  );

  // R12: flow characters and a remote pause both block queued data
  assign data_grant = ~tx_pause & ~inj_req;
endmodule

// File: tb/tb_swflow_ctrl.sv
`timescale 1ns/1ps
module tb_swflow_ctrl;
  localparam logic [7:0] ONA = 8'h11, ONB = 8'h12, OFFA = 8'h13, OFFB = 8'h14, DAT = 8'h41;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic [1:0] cmp_mode = 2'b00, gen_mode = 2'b00;
  logic [7:0] fifo_level = '0;
  logic [7:0] thresh_cfg = '0;
  logic       tx_busy = 1'b0, inj_ack = 1'b0, stat_clr = 1'b0;
  logic       rx_fwd_valid, tx_pause, data_grant, inj_req;
  logic [7:0] rx_fwd_char, inj_char;
  logic [3:0] stat;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  swflow_ctrl dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .cmp_mode(cmp_mode), .gen_mode(gen_mode),
    .xon_a_code(ONA), .xon_b_code(ONB), .xoff_a_code(OFFA), .xoff_b_code(OFFB),
    .fifo_level(fifo_level), .thresh_cfg(thresh_cfg), .tx_busy(tx_busy),
    .inj_ack(inj_ack), .stat_clr(stat_clr),
    .rx_fwd_valid(rx_fwd_valid), .rx_fwd_char(rx_fwd_char), .tx_pause(tx_pause),
    .data_grant(data_grant), .inj_req(inj_req), .inj_char(inj_char), .stat(stat)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  // one strobe, then sample at the next falling edge
  task automatic send_rx(input logic [7:0] ch, input logic clr);
    rx_valid = 1'b1; rx_char = ch; stat_clr = clr;
    @(negedge clk);
    rx_valid = 1'b0; stat_clr = 1'b0;
  endtask

  task automatic clear_stat();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic ack();
    inj_ack = 1'b1;
    @(negedge clk);
    inj_ack = 1'b0;
  endtask

  task automatic set_level(input logic [7:0] lv);
    fifo_level = lv;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 fwd_valid", rx_fwd_valid, 0);
    chk("R1 tx_pause", tx_pause, 0);
    chk("R1 inj_req", inj_req, 0);
    chk("R1 stat", stat, 0);
    chk("R1 data_grant", data_grant, 1);
  endtask

  task automatic t_mode_none();
    cmp_mode = 2'b00;
    send_rx(OFFB, 1'b0);
    chk("R2 fwd_valid", rx_fwd_valid, 1);
    chk("R2 fwd_char", rx_fwd_char, OFFB);
    chk("R2 no pause", tx_pause, 0);
    chk("R2 no status", stat, 0);
  endtask

  task automatic t_mode_b();
    cmp_mode = 2'b01;
    send_rx(OFFA, 1'b0);
    chk("R3 set A passes", rx_fwd_valid, 1);
    chk("R3 set A no pause", tx_pause, 0);
    send_rx(OFFB, 1'b0);
    chk("R7 consumed", rx_fwd_valid, 0);
    chk("R3 pause", tx_pause, 1);
    chk("R12 grant low when paused", data_grant, 0);
    chk("R8 bit3", stat, 4'b1000);
    send_rx(ONB, 1'b0);
    chk("R3 resume", tx_pause, 0);
    chk("R8 bit1 sticky", stat, 4'b1010);
    clear_stat();
    chk("R8 clear", stat, 0);
  endtask

  task automatic t_mode_a();
    cmp_mode = 2'b10;
    send_rx(OFFB, 1'b0);
    chk("R4 set B passes", rx_fwd_valid, 1);
    send_rx(OFFA, 1'b0);
    chk("R4 pause", tx_pause, 1);
    chk("R8 bit2", stat, 4'b0100);
    send_rx(ONA, 1'b0);
    chk("R4 resume", tx_pause, 0);
    chk("R8 bit0", stat, 4'b0101);
    clear_stat();
  endtask

  task automatic t_mode_both();
    cmp_mode = 2'b11;
    send_rx(OFFA, 1'b0);
    chk("R5 first half consumed", rx_fwd_valid, 0);
    chk("R5 first half no pause", tx_pause, 0);
    send_rx(DAT, 1'b0);
    chk("R5 data passes", rx_fwd_valid, 1);
    send_rx(OFFB, 1'b0);
    chk("R5 broken pair no pause", tx_pause, 0);
    send_rx(OFFA, 1'b0);
    send_rx(OFFB, 1'b0);
    chk("R5 pair pauses", tx_pause, 1);
    chk("R5 status", stat, 4'b1100);
    send_rx(ONB, 1'b0);
    chk("R5 lone second half no resume", tx_pause, 1);
    send_rx(ONA, 1'b0);
    send_rx(ONB, 1'b0);
    chk("R5 pair resumes", tx_pause, 0);
    chk("R5 all status", stat, 4'b1111);
    clear_stat();
  endtask

  task automatic t_busy();
    cmp_mode = 2'b01;
    tx_busy = 1'b1;
    send_rx(OFFB, 1'b0);
    chk("R6 held while busy", tx_pause, 0);
    @(negedge clk);
    chk("R6 still held", tx_pause, 0);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R6 pause after idle", tx_pause, 1);
    send_rx(ONB, 1'b0);
    chk("R6 resume", tx_pause, 0);
    tx_busy = 1'b1;
    send_rx(OFFB, 1'b0);
    send_rx(ONB, 1'b0);
    tx_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 pending cancelled", tx_pause, 0);
    clear_stat();
  endtask

  task automatic t_stat_race();
    cmp_mode = 2'b01;
    send_rx(OFFB, 1'b0);
    chk("R8 before race", stat, 4'b1000);
    send_rx(ONB, 1'b1);
    chk("R8 set wins over clear", stat, 4'b0010);
    clear_stat();
    cmp_mode = 2'b00;
  endtask

  task automatic t_gen_b();
    thresh_cfg = 8'h26;   // halt 48, resume 16
    gen_mode = 2'b01;
    set_level(8'd47);
    chk("R9 below halt", inj_req, 0);
    set_level(8'd48);
    chk("R10 halt request", inj_req, 1);
    chk("R11 set B pause code", inj_char, OFFB);
    chk("R12 grant low", data_grant, 0);
    @(negedge clk);
    chk("R12 held", inj_req, 1);
    chk("R12 char held", inj_char, OFFB);
    ack();
    chk("R12 released", inj_req, 0);
    set_level(8'd60);
    chk("R10 no repeat", inj_req, 0);
    set_level(8'd17);
    chk("R9 above resume", inj_req, 0);
    set_level(8'd16);
    chk("R10 resume request", inj_req, 1);
    chk("R11 set B resume code", inj_char, ONB);
    ack();
  endtask

  task automatic t_gen_both();
    gen_mode = 2'b11;
    set_level(8'd48);
    chk("R11 pair first", inj_char, OFFA);
    ack();
    chk("R11 pair still req", inj_req, 1);
    chk("R11 pair second", inj_char, OFFB);
    ack();
    chk("R11 pair done", inj_req, 0);
    set_level(8'd0);
    chk("R11 resume first", inj_char, ONA);
    ack();
    chk("R11 resume second", inj_char, ONB);
    ack();
    chk("R11 resume done", inj_req, 0);
  endtask

  task automatic t_gen_a_none();
    gen_mode = 2'b10;
    set_level(8'd48);
    chk("R11 set A pause code", inj_char, OFFA);
    ack();
    set_level(8'd10);
    chk("R11 set A resume code", inj_char, ONA);
    ack();
    gen_mode = 2'b00;
    set_level(8'd48);
    chk("R11 mode 00 silent", inj_req, 0);
    @(negedge clk);
    chk("R11 mode 00 still silent", inj_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_none();
    t_mode_b();
    t_mode_a();
    t_mode_both();
    t_busy();
    t_stat_race();
    t_gen_b();
    t_gen_both();
    t_gen_a_none();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule